// File: doc/BRIEF.md
# LIN Frame Response Engine

This block handles the response section of a LIN frame once the header is on the wire. On a one-cycle frame start it captures the configuration and the six-bit frame identifier. It then builds the protected identifier with its two parity bits and works out how many data bytes the response carries. After that it runs one of three roles. In the sending role it pulls bytes from the host and hands them to the UART shifter, then appends a checksum. In the receiving role it passes shifter bytes to the host and checks the trailing checksum. In the ignoring role it moves no data at all.

The response length is either an explicit count field plus one, or it is decoded from the two upper identifier bits. The checksum runs over the data alone (classic form) or over the protected identifier and the data (enhanced form). Parity handling and checksum handling can each be switched off on their own. The block compares the identifier byte seen on the line with its own parity. A parity or checksum fault sets a sticky error flag. That flag is read together with a one-cycle frame-done pulse.

Top module: `lin_resp_engine`

## Requirements
- R1: `cfg_action` is sampled at frame start. Code 0 sends the response. Code 1 receives it. Codes 2 and 3 move no byte on any port, and `done` pulses in the cycle after the frame start is accepted.
- R2: With `cfg_len_mode` = 0 the response carries `cfg_len` + 1 data bytes (1 to 256).
- R3: With `cfg_len_mode` = 1 the count comes from `frame_id[5:4]`: 00 gives 2, 01 gives 2, 10 gives 4 and 11 gives 8 data bytes.
- R4: `pid` holds the captured identifier in bits 5:0. Bit 6 is id0^id1^id2^id4 and bit 7 is the inverse of id1^id3^id4^id5.
- R5: The checksum is an 8-bit sum in which a carry out of bit 7 is added back in, and the result is inverted. With `cfg_csum_classic` = 0 the sum starts from `pid`; with 1 it starts from zero. In the sending role the checksum byte follows the last data byte on `tx_data`.
- R6: With `cfg_csum_off` = 1 no checksum byte is sent or awaited, and `done` follows the last data byte directly.
- R7: With `cfg_par_off` = 1, `pid[7:6]` reads 00 and no parity fault is raised, whatever `bus_pid` holds.
- R8: With `cfg_par_off` = 0, a frame start whose `bus_pid[7:6]` differs from the parity of `bus_pid[5:0]` sets `err`.
- R9: In the receiving role, if the checksum sum of the covered bytes and the received checksum byte is not 0xFF, `err` is set. `err` keeps its value until the next accepted frame start and is valid while `done` is high.
- R10: `done` is high for exactly one cycle, in the cycle after the last byte transfer. `busy` is high from the cycle after frame start until that transfer.
- R11: Configuration inputs, the identifier and `frame_start` have no effect while `busy` is high.
- R12: In the receiving role each data byte on `rx_data` with `rx_valid` appears on `host_rx_data` with `host_rx_valid` in the same cycle, in order. The checksum byte is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that starts a response |
| cfg_action | input | 2 | Role: 0 send, 1 receive, 2/3 ignore |
| cfg_len_mode | input | 1 | 0 explicit count, 1 identifier-derived count |
| cfg_len | input | LEN_W | Explicit count minus one |
| cfg_csum_classic | input | 1 | 1 data-only checksum, 0 identifier included |
| cfg_csum_off | input | 1 | 1 disables checksum |
| cfg_par_off | input | 1 | 1 disables parity |
| frame_id | input | 6 | Frame identifier |
| bus_pid | input | 8 | Identifier byte observed on the line |
| pid | output | 8 | Protected identifier of the current frame |
| host_tx_valid | input | 1 | Host offers a data byte to send |
| host_tx_data | input | 8 | Data byte to send |
| host_tx_ready | output | 1 | Byte taken from host |
| tx_valid | output | 1 | Byte offered to UART shifter |
| tx_data | output | 8 | Byte toward UART shifter |
| tx_ready | input | 1 | Shifter accepts byte |
| rx_valid | input | 1 | Shifter delivers a byte |
| rx_data | input | 8 | Received byte |
| host_rx_valid | output | 1 | Data byte delivered to host |
| host_rx_data | output | 8 | Received data byte |
| busy | output | 1 | Response in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Sticky parity/checksum fault |

## Verification
The assertions assume that the shifter raises `rx_valid` only during a receiving frame, and that the host keeps `host_tx_valid` low outside a sending frame. They also assume that `frame_start` is a single-cycle pulse. The stimulus drives bytes only between the frame start and the `done` pulse of the matching role, and it releases each request one cycle after it is taken. One frame deliberately pulses `frame_start` and changes every configuration input while a response is running, to show they are ignored.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;

    localparam int LIN_BYTE_W = 8;
    localparam int LIN_ID_W   = 6;

    typedef enum logic [1:0] {
        ACT_SEND   = 2'd0,
        ACT_RECV   = 2'd1,
        ACT_SKIP   = 2'd2,
        ACT_RSVD   = 2'd3
    } lin_act_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_SUM  = 2'd2
    } lin_state_e;

    // eight-bit addition with the carry folded back into bit 0
    function automatic logic [LIN_BYTE_W-1:0] sum_fold(
        input logic [LIN_BYTE_W-1:0] a,
        input logic [LIN_BYTE_W-1:0] b
    );
        logic [LIN_BYTE_W:0] raw;
        raw = {1'b0, a} + {1'b0, b};
        return raw[LIN_BYTE_W-1:0] + {{(LIN_BYTE_W-1){1'b0}}, raw[LIN_BYTE_W]};
    endfunction

endpackage

// File: rtl/lin_id_parity.sv
module lin_id_parity
    import lin_resp_pkg::*;
(
    input  logic [LIN_ID_W-1:0] id,
    output logic [1:0]          par
);
    always_comb begin
        par[0] = id[0] ^ id[1] ^ id[2] ^ id[4];
        par[1] = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    end
endmodule

// File: rtl/lin_len_calc.sv
module lin_len_calc #(
    parameter int LEN_W = 8
) (
    input  logic             len_mode,
    input  logic [LEN_W-1:0] len_field,
    input  logic [1:0]       id_len,
    output logic [LEN_W-1:0] last_idx
);
    localparam logic [LEN_W-1:0] LAST_OF_2 = LEN_W'(1);
    localparam logic [LEN_W-1:0] LAST_OF_4 = LEN_W'(3);
    localparam logic [LEN_W-1:0] LAST_OF_8 = LEN_W'(7);

    always_comb begin
        if (!len_mode) begin
            last_idx = len_field;
        end else begin
            case (id_len)
                2'b10:   last_idx = LAST_OF_4;
                2'b11:   last_idx = LAST_OF_8;
                default: last_idx = LAST_OF_2;
            endcase
        end
    end
endmodule

// File: rtl/lin_csum_acc.sv
module lin_csum_acc
    import lin_resp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [LIN_BYTE_W-1:0] load_val,
    input  logic                  add,
    input  logic [LIN_BYTE_W-1:0] add_byte,
    output logic [LIN_BYTE_W-1:0] sum
);
    logic [LIN_BYTE_W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (load) begin
            sum_d = load_val;
        end else if (add) begin
            sum_d = sum_fold(sum_q, add_byte);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;
endmodule

// File: rtl/lin_resp_engine.sv
module lin_resp_engine
    import lin_resp_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic [1:0]            cfg_action,
    input  logic                  cfg_len_mode,
    input  logic [LEN_W-1:0]      cfg_len,
    input  logic                  cfg_csum_classic,
    input  logic                  cfg_csum_off,
    input  logic                  cfg_par_off,
    input  logic [LIN_ID_W-1:0]   frame_id,
    input  logic [LIN_BYTE_W-1:0] bus_pid,
    output logic [LIN_BYTE_W-1:0] pid,
    input  logic                  host_tx_valid,
    input  logic [LIN_BYTE_W-1:0] host_tx_data,
    output logic                  host_tx_ready,
    output logic                  tx_valid,
    output logic [LIN_BYTE_W-1:0] tx_data,
    input  logic                  tx_ready,
    input  logic                  rx_valid,
    input  logic [LIN_BYTE_W-1:0] rx_data,
    output logic                  host_rx_valid,
    output logic [LIN_BYTE_W-1:0] host_rx_data,
    output logic                  busy,
    output logic                  done,
    output logic                  err
);
    localparam logic [LEN_W-1:0]      CNT_ONE  = LEN_W'(1);
    localparam logic [LIN_BYTE_W-1:0] SUM_GOOD = '1;

    typedef struct packed {
        lin_act_e            act;
        logic                csum_off;
        logic                par_off;
        logic [LIN_ID_W-1:0] id;
    } frame_cfg_t;

    typedef struct packed {
        lin_state_e  state;
        frame_cfg_t  cfg;
        logic [LEN_W-1:0] remain;
        logic        err;
        logic        done;
    } eng_t;

    eng_t eng_d, eng_q;

    // parity of the incoming identifier (for the start-up sum) and of the held one
    logic [1:0]            par_new, par_held, par_bus;
    logic [LIN_BYTE_W-1:0] pid_new;
    logic [LEN_W-1:0]      last_new;
    logic [LIN_BYTE_W-1:0] sum_q;

    lin_id_parity u_par_new  (.id(frame_id),      .par(par_new));
    lin_id_parity u_par_held (.id(eng_q.cfg.id),  .par(par_held));
    lin_id_parity u_par_bus  (.id(bus_pid[LIN_ID_W-1:0]), .par(par_bus));

    lin_len_calc #(.LEN_W(LEN_W)) u_len (
        .len_mode  (cfg_len_mode),
        .len_field (cfg_len),
        .id_len    (frame_id[LIN_ID_W-1:LIN_ID_W-2]),
        .last_idx  (last_new)
    );

    assign pid_new = cfg_par_off ? {2'b00, frame_id} : {par_new, frame_id};
    assign pid     = eng_q.cfg.par_off ? {2'b00, eng_q.cfg.id} : {par_held, eng_q.cfg.id};

    logic is_send, is_recv, in_data, in_sum;
    logic data_fire, sum_fire, start_ok;
    logic [LIN_BYTE_W-1:0] data_byte;

    always_comb begin
        is_send   = (eng_q.cfg.act == ACT_SEND);
        is_recv   = (eng_q.cfg.act == ACT_RECV);
        in_data   = (eng_q.state == ST_DATA);
        in_sum    = (eng_q.state == ST_SUM);
        start_ok  = (eng_q.state == ST_IDLE) && frame_start;
        data_fire = in_data && (is_send ? (host_tx_valid && tx_ready) : (is_recv && rx_valid));
        sum_fire  = in_sum && (is_send ? tx_ready : (is_recv && rx_valid));
        data_byte = is_send ? host_tx_data : rx_data;
    end

    lin_csum_acc u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .load_val (cfg_csum_classic ? '0 : pid_new),
        .add      (data_fire),
        .add_byte (data_byte),
        .sum      (sum_q)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        case (eng_q.state)
            ST_IDLE: begin
                if (frame_start) begin
                    eng_d.cfg.act      = lin_act_e'(cfg_action);
                    eng_d.cfg.csum_off = cfg_csum_off;
                    eng_d.cfg.par_off  = cfg_par_off;
                    eng_d.cfg.id       = frame_id;
                    eng_d.remain       = last_new;
                    eng_d.err          = !cfg_par_off &&
                                         (bus_pid[LIN_BYTE_W-1:LIN_ID_W] != par_bus);
                    if (cfg_action == ACT_SEND || cfg_action == ACT_RECV) begin
                        eng_d.state = ST_DATA;
                    end else begin
                        eng_d.done  = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (data_fire) begin
                    if (eng_q.remain == '0) begin
                        if (eng_q.cfg.csum_off) begin
                            eng_d.state = ST_IDLE;
                            eng_d.done  = 1'b1;
                        end else begin
                            eng_d.state = ST_SUM;
                        end
                    end else begin
                        eng_d.remain = eng_q.remain - CNT_ONE;
                    end
                end
            end
            ST_SUM: begin
                if (sum_fire) begin
                    if (is_recv && sum_fold(sum_q, rx_data) != SUM_GOOD) begin
                        eng_d.err = 1'b1;
                    end
                    eng_d.state = ST_IDLE;
                    eng_d.done  = 1'b1;
                end
            end
            default: eng_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign host_tx_ready = is_send && in_data && tx_ready;
    assign tx_valid      = is_send && ((in_data && host_tx_valid) || in_sum);
    assign tx_data       = in_sum ? ~sum_q : host_tx_data;
    assign host_rx_valid = is_recv && in_data && rx_valid;
    assign host_rx_data  = rx_data;
    assign busy          = (eng_q.state != ST_IDLE);
    assign done          = eng_q.done;
    assign err           = eng_q.err;

    AST_TX_ONLY_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (busy && eng_q.cfg.act == ACT_SEND)); // R1
    AST_HOST_RX_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        host_rx_valid |-> (eng_q.state == ST_DATA && eng_q.cfg.act == ACT_RECV)); // R12
    AST_NO_SUM_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_SUM) |-> !eng_q.cfg.csum_off); // R6
    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && err) |=> err); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(eng_q.cfg)); // R11
endmodule

// File: tb/test_lin_resp_engine.sv
`timescale 1ns/1ps
module test_lin_resp_engine;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       frame_start;
    logic [1:0] cfg_action;
    logic       cfg_len_mode;
    logic [7:0] cfg_len;
    logic       cfg_csum_classic, cfg_csum_off, cfg_par_off;
    logic [5:0] frame_id;
    logic [7:0] bus_pid, pid;
    logic       host_tx_valid, host_tx_ready;
    logic [7:0] host_tx_data;
    logic       tx_valid, tx_ready;
    logic [7:0] tx_data;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       host_rx_valid;
    logic [7:0] host_rx_data;
    logic       busy, done, err;

    lin_resp_engine i_lin_resp_engine (.*);

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_tx_q[$];
    logic [7:0] exp_hrx_q[$];
    logic [7:0] dat[256];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_pid(input logic [5:0] id, input bit off);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return off ? {2'b00, id} : {p1, p0, id};
    endfunction

    function automatic logic [7:0] ref_add(input logic [7:0] a, input logic [7:0] b);
        int s;
        s = int'(a) + int'(b);
        if (s > 255) s = s - 255;
        return s[7:0];
    endfunction

    function automatic int ref_len(input bit mode, input logic [7:0] len, input logic [5:0] id);
        if (!mode) return int'(len) + 1;
        case (id[5:4])
            2'b10:   return 4;
            2'b11:   return 8;
            default: return 2;
        endcase
    endfunction

    // scoreboard monitor: samples between clock edges
    always @(negedge clk) begin
        logic [7:0] e;
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (exp_tx_q.size() == 0) check(1'b0, "R1", "unexpected tx byte", tx_data, 0);
                else begin
                    e = exp_tx_q.pop_front();
                    check(tx_data == e, "R5", "tx byte", tx_data, e);
                end
            end
            if (host_rx_valid) begin
                if (exp_hrx_q.size() == 0) check(1'b0, "R12", "unexpected host rx byte", host_rx_data, 0);
                else begin
                    e = exp_hrx_q.pop_front();
                    check(host_rx_data == e, "R12", "host rx byte", host_rx_data, e);
                end
            end
        end
    end

    task automatic start_frame(input logic [1:0] act, input bit mode, input logic [7:0] len,
                               input bit classic, input bit off, input bit paroff,
                               input logic [5:0] id, input logic [7:0] bpid);
        @(posedge clk); #1;
        cfg_action = act; cfg_len_mode = mode; cfg_len = len;
        cfg_csum_classic = classic; cfg_csum_off = off; cfg_par_off = paroff;
        frame_id = id; bus_pid = bpid; frame_start = 1'b1;
        @(posedge clk); #1;
        frame_start = 1'b0;
    endtask

    task automatic wait_done(input bit exp_err, input string req);
        int n = 0;
        do begin
            @(negedge clk); n++;
        end while (!done && n < 2000);
        check(done, "R10", "done pulse seen", done, 1);
        check(err == exp_err, req, "err at done", err, exp_err);
        @(negedge clk);
        check(!done && !busy, "R10", "done one cycle, idle", {done, busy}, 0);
    endtask

    task automatic send_frame(input bit mode, input logic [7:0] len, input bit classic,
                              input bit off, input bit paroff, input logic [5:0] id,
                              input bit stall, input bit disturb, input string req);
        int cnt;
        logic [7:0] s;
        cnt = ref_len(mode, len, id);
        s = classic ? 8'h00 : ref_pid(id, paroff);
        for (int i = 0; i < cnt; i++) begin
            dat[i] = 8'(i * 37 + int'(id) + 5);
            s = ref_add(s, dat[i]);
            exp_tx_q.push_back(dat[i]);
        end
        if (!off) exp_tx_q.push_back(~s);
        start_frame(2'd0, mode, len, classic, off, paroff, id, ref_pid(id, 1'b0));
        check(pid == ref_pid(id, paroff), "R4", "protected id", pid, ref_pid(id, paroff));
        if (disturb) begin
            // R11: everything changes and a new start arrives while busy
            cfg_action = 2'd1; cfg_len = 8'h00; cfg_len_mode = ~mode;
            cfg_csum_off = ~off; cfg_csum_classic = ~classic; frame_id = ~id;
            frame_start = 1'b1;
            @(posedge clk); #1;
            frame_start = 1'b0;
            check(pid == ref_pid(id, paroff), "R11", "pid held", pid, ref_pid(id, paroff));
        end
        for (int i = 0; i < cnt; i++) begin
            if (stall && (i % 3 == 1)) begin
                tx_ready = 1'b0;
                host_tx_valid = 1'b1; host_tx_data = dat[i];
                @(posedge clk); #1;
                tx_ready = 1'b1;
            end
            host_tx_valid = 1'b1; host_tx_data = dat[i];
            do @(negedge clk); while (!host_tx_ready);
            @(posedge clk); #1;
        end
        host_tx_valid = 1'b0;
        wait_done(1'b0, req);
        check(exp_tx_q.size() == 0, req, "all tx bytes seen", exp_tx_q.size(), 0);
    endtask

    task automatic recv_frame(input bit mode, input logic [7:0] len, input bit classic,
                              input bit off, input logic [5:0] id, input bit corrupt,
                              input bit exp_err, input string req);
        int cnt;
        logic [7:0] s;
        cnt = ref_len(mode, len, id);
        s = classic ? 8'h00 : ref_pid(id, 1'b0);
        for (int i = 0; i < cnt; i++) begin
            dat[i] = 8'(i * 91 + 200);
            s = ref_add(s, dat[i]);
            exp_hrx_q.push_back(dat[i]);
        end
        start_frame(2'd1, mode, len, classic, off, 1'b0, id, ref_pid(id, 1'b0));
        for (int i = 0; i < cnt; i++) begin
            rx_valid = 1'b1; rx_data = dat[i];
            @(posedge clk); #1;
        end
        if (!off) begin
            rx_valid = 1'b1; rx_data = corrupt ? (~s ^ 8'h01) : ~s;
            @(posedge clk); #1;
        end
        rx_valid = 1'b0;
        wait_done(exp_err, req);
        check(exp_hrx_q.size() == 0, req, "all rx bytes forwarded", exp_hrx_q.size(), 0);
    endtask

    task automatic skip_frame(input logic [1:0] act, input bit paroff, input logic [5:0] id,
                              input logic [7:0] bpid, input bit exp_err, input string req);
        start_frame(act, 1'b0, 8'h03, 1'b0, 1'b0, paroff, id, bpid);
        @(negedge clk);
        check(done && !busy, "R1", "ignore ends next cycle", {done, busy}, 2);
        check(err == exp_err, req, "parity flag", err, exp_err);
        check(pid == ref_pid(id, paroff), "R7", "pid parity bits", pid, ref_pid(id, paroff));
        @(negedge clk);
        check(!done, "R10", "done single cycle", done, 0);
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; frame_start = 1'b0; cfg_action = 2'd2; cfg_len_mode = 1'b0;
        cfg_len = 8'h00; cfg_csum_classic = 1'b0; cfg_csum_off = 1'b0; cfg_par_off = 1'b0;
        frame_id = 6'h00; bus_pid = 8'h00; host_tx_valid = 1'b0; host_tx_data = 8'h00;
        tx_ready = 1'b1; rx_valid = 1'b0; rx_data = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && !tx_valid && !host_rx_valid, "R10", "reset state",
              {busy, done, err, tx_valid, host_rx_valid}, 0);

        send_frame(1'b0, 8'd2, 1'b0, 1'b0, 1'b0, 6'h01, 1'b1, 1'b0, "R2");    // enhanced, stalls
        send_frame(1'b1, 8'd0, 1'b1, 1'b0, 1'b0, 6'h3A, 1'b0, 1'b0, "R3");    // id bits 11 -> 8
        send_frame(1'b1, 8'd0, 1'b0, 1'b0, 1'b0, 6'h25, 1'b0, 1'b0, "R3");    // id bits 10 -> 4
        send_frame(1'b0, 8'd4, 1'b0, 1'b1, 1'b0, 6'h11, 1'b0, 1'b0, "R6");    // no checksum
        send_frame(1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 6'h0F, 1'b0, 1'b0, "R5");    // 1 byte, parity off
        send_frame(1'b0, 8'd255, 1'b0, 1'b0, 1'b0, 6'h2C, 1'b0, 1'b0, "R2");  // 256 bytes
        send_frame(1'b0, 8'd3, 1'b0, 1'b0, 1'b0, 6'h07, 1'b0, 1'b1, "R11");   // disturbed
        recv_frame(1'b1, 8'd9, 1'b0, 1'b0, 6'h10, 1'b0, 1'b0, "R12");         // id bits 01 -> 2
        recv_frame(1'b0, 8'd5, 1'b1, 1'b0, 6'h03, 1'b0, 1'b0, "R5");
        recv_frame(1'b0, 8'd2, 1'b0, 1'b0, 6'h21, 1'b1, 1'b1, "R9");          // bad checksum
        recv_frame(1'b1, 8'd0, 1'b0, 1'b1, 6'h3F, 1'b0, 1'b0, "R6");          // no checksum
        skip_frame(2'd2, 1'b0, 6'h01, ref_pid(6'h01, 1'b0), 1'b0, "R1");
        skip_frame(2'd3, 1'b0, 6'h10, ref_pid(6'h10, 1'b0) ^ 8'h80, 1'b1, "R8");
        skip_frame(2'd2, 1'b1, 6'h10, 8'hD0, 1'b0, "R7");
        recv_frame(1'b0, 8'd1, 1'b0, 1'b0, 6'h05, 1'b0, 1'b0, "R9");          // err clears

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule